// File: doc/BRIEF.md
# Registered Bidirectional Parity Transceiver

This block moves data between an A side and a B side, one direction at a time or both at once. Each side is 18 bits wide and is split into two 9-bit lanes. In each lane, bits 7:0 are data and bit 8 is parity. Lane 0 occupies port bits 8:0 and lane 1 occupies bits 17:9. Each direction has its own storage stage with its own clock, latch enable and per-lane clock enable. The stage is transparent while its latch enable is high. While the latch enable is low, it acts as a clock-enabled register.

With parity mode on (`bypass` low), each outgoing lane carries its stored 8 data bits and a freshly generated parity bit. The received parity bit is dropped from the output. It is still checked, together with the 8 stored data bits, against the odd/even setting. Each side has one active-low error flag per lane. With `bypass` high, all 18 bits pass through unchanged and every error flag stays high.

The tri-state pins are modelled as separate input, output and output-enable signals. The two output-enable controls choose which side drives. The storage stage is built from flip-flops with a transparent bypass. When the latch enable falls, the stage therefore keeps the word loaded at the last rising edge while it was high.

Top module: `parity_xcvr`

## Requirements
- R1: While `rst_n` is low, both storage stages clear to zero. Right after reset, with the latch enables low, the outputs show a zero word. In parity mode that word is regenerated, so with odd sense each lane's bit 8 is 1 and all four error flags are low.
- R2: While `le_ab` is high, `b_out` follows `a_in` in the same cycle, and the A-to-B register loads on every rising edge of `clk_ab`.
- R3: While `le_ab` is low, lane i of the A-to-B stage loads its 9 bits from `a_in` on a rising edge of `clk_ab` only when `cen_ab[i]` is high.
- R4: While the latch enable is low and `cen_ab[i]` is low, lane i holds its value across clock edges, whatever the input.
- R5: In parity mode, lane bits 7:0 of the output equal the stored data bits. Bit 8 is the XOR of those bits, inverted when `odd_sel` is 1.
- R6: With `odd_sel` = 1, each output lane has odd weight across all 9 bits. With `odd_sel` = 0, it has even weight.
- R7: In parity mode, `err_a_n[i]` is low exactly when the XOR of the 9 stored bits of lane i from A differs from `odd_sel`. `err_b_n[i]` follows the same rule for data from B.
- R8: With `bypass` high, each output equals its stored 18 bits unchanged, and all error flags are high.
- R9: `b_oe` equals `oe_ab` and `a_oe` equals `oe_ba`. The output value buses are driven whatever the enables are.
- R10: The B-to-A path uses only `clk_ba`, `le_ba` and `cen_ba`, applies R2 to R4 to `b_in` and `a_out`, and is unaffected by the A-to-B controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | A-to-B storage clock |
| clk_ba | input | 1 | B-to-A storage clock |
| rst_n | input | 1 | Asynchronous active-low reset of both stages |
| le_ab | input | 1 | A-to-B transparent enable (high = transparent) |
| le_ba | input | 1 | B-to-A transparent enable |
| cen_ab | input | 2 | A-to-B per-lane clock enable, active high |
| cen_ba | input | 2 | B-to-A per-lane clock enable, active high |
| oe_ab | input | 1 | Drive B side |
| oe_ba | input | 1 | Drive A side |
| bypass | input | 1 | 1 = parity off, plain 18-bit pass-through |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| a_in | input | 18 | Value received on the A side |
| a_out | output | 18 | Value driven on the A side |
| a_oe | output | 1 | A side driver enable |
| b_in | input | 18 | Value received on the B side |
| b_out | output | 18 | Value driven on the B side |
| b_oe | output | 1 | B side driver enable |
| err_a_n | output | 2 | Per-lane parity error on data from A, active low |
| err_b_n | output | 2 | Per-lane parity error on data from B, active low |

## Verification
Directed patterns come first. Single-bit flips, first of the parity bit in lane 1 and then of a data bit in lane 0, show that each error flag follows only its own lane and that the parity bit is regenerated rather than forwarded. Walking the clock enables one lane at a time with a full-ones word, then with a checkerboard, separates load from hold for each lane. Long random runs mix the latch and register modes, both parity senses, bypass and both directions. These are compared against a bench model of the two storage stages, which exposes any coupling between lanes or between the two directions.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;
   typedef enum logic {PAR_EVEN = 1'b0, PAR_ODD = 1'b1} par_sense_e;
   localparam int DEF_LANES  = 2;
   localparam int DEF_LANE_W = 8;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           le,
   input  logic [LANES-1:0]               cen,
   input  logic [LANES*(LANE_W+1)-1:0]    d,
   output logic [LANES*(LANE_W+1)-1:0]    q
);
   localparam int LW = LANE_W + 1;
   localparam int W  = LANES * LW;

   logic [W-1:0] held;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            held[g*LW +: LW] <= '0;
         else if (le || cen[g])
            held[g*LW +: LW] <= d[g*LW +: LW];
      end

      // R4: a disabled lane in register mode keeps its contents
      a_r4_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (!le && !cen[g]) |=> $stable(held[g*LW +: LW]));

      // R3: an enabled lane in register mode takes the input word
      a_r3_lane_load: assert property (@(posedge clk) disable iff (!rst_n)
         (!le && cen[g]) |=> (held[g*LW +: LW] == $past(d[g*LW +: LW])));
   end

   assign q = le ? d : held;
endmodule

// File: rtl/xcvr_lane_par.sv
module xcvr_lane_par #(
   parameter int LANE_W = 8
) (
   input  logic            bypass,
   input  logic            odd_sel,
   input  logic [LANE_W:0] stored,
   output logic [LANE_W:0] out,
   output logic            err_n
);
   logic dpar;
   logic rx_ok;

   assign dpar  = ^stored[LANE_W-1:0];
   assign rx_ok = ((^stored) == odd_sel);
   assign out   = bypass ? stored : {dpar ^ odd_sel, stored[LANE_W-1:0]};
   assign err_n = bypass | rx_ok;
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           le,
   input  logic [LANES-1:0]               cen,
   input  logic                           bypass,
   input  logic                           odd_sel,
   input  logic [LANES*(LANE_W+1)-1:0]    d,
   output logic [LANES*(LANE_W+1)-1:0]    q_out,
   output logic [LANES-1:0]               err_n
);
   localparam int LW = LANE_W + 1;
   localparam int W  = LANES * LW;

   logic [W-1:0] stored;

   xcvr_store #(.LANES(LANES), .LANE_W(LANE_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .le    (le),
      .cen   (cen),
      .d     (d),
      .q     (stored)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_par
      xcvr_lane_par #(.LANE_W(LANE_W)) u_par (
         .bypass  (bypass),
         .odd_sel (odd_sel),
         .stored  (stored[g*LW +: LW]),
         .out     (q_out[g*LW +: LW]),
         .err_n   (err_n[g])
      );

      // R6: generated lanes carry the selected weight
      a_r6_out_sense: assert property (@(posedge clk) disable iff (!rst_n)
         !bypass |-> ((^q_out[g*LW +: LW]) == odd_sel));

      // R5: data bits pass through the parity stage unchanged
      a_r5_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |-> (q_out[g*LW +: LANE_W] == stored[g*LW +: LANE_W]));
   end

   // R8: pass-through mode leaves the stored word intact
   a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |-> (q_out == stored));
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
   parameter int LANES  = parity_xcvr_pkg::DEF_LANES,
   parameter int LANE_W = parity_xcvr_pkg::DEF_LANE_W
) (
   input  logic                          clk_ab,
   input  logic                          clk_ba,
   input  logic                          rst_n,
   input  logic                          le_ab,
   input  logic                          le_ba,
   input  logic [LANES-1:0]              cen_ab,
   input  logic [LANES-1:0]              cen_ba,
   input  logic                          oe_ab,
   input  logic                          oe_ba,
   input  logic                          bypass,
   input  logic                          odd_sel,
   input  logic [LANES*(LANE_W+1)-1:0]   a_in,
   output logic [LANES*(LANE_W+1)-1:0]   a_out,
   output logic                          a_oe,
   input  logic [LANES*(LANE_W+1)-1:0]   b_in,
   output logic [LANES*(LANE_W+1)-1:0]   b_out,
   output logic                          b_oe,
   output logic [LANES-1:0]              err_a_n,
   output logic [LANES-1:0]              err_b_n
);
   if (LANES < 1) begin : g_bad_lanes
      $error("parity_xcvr: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("parity_xcvr: LANE_W must be at least 1");
   end

   xcvr_path #(.LANES(LANES), .LANE_W(LANE_W)) u_ab (
      .clk     (clk_ab),
      .rst_n   (rst_n),
      .le      (le_ab),
      .cen     (cen_ab),
      .bypass  (bypass),
      .odd_sel (odd_sel),
      .d       (a_in),
      .q_out   (b_out),
      .err_n   (err_a_n)
   );

   xcvr_path #(.LANES(LANES), .LANE_W(LANE_W)) u_ba (
      .clk     (clk_ba),
      .rst_n   (rst_n),
      .le      (le_ba),
      .cen     (cen_ba),
      .bypass  (bypass),
      .odd_sel (odd_sel),
      .d       (b_in),
      .q_out   (a_out),
      .err_n   (err_b_n)
   );

   assign b_oe = oe_ab;
   assign a_oe = oe_ba;

   // R9: each side's driver enable tracks its direction control
   a_r9_oe_map: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (b_oe == oe_ab) && (a_oe == oe_ba));

   // R8: no error is flagged while parity is off
   a_r8_no_err: assert property (@(posedge clk_ab) disable iff (!rst_n)
      bypass |-> (&{err_a_n, err_b_n}));
endmodule

// File: tb/parity_xcvr_test.sv
module parity_xcvr_test;
   localparam int LANES = 2;
   localparam int LW    = 9;
   localparam int W     = LANES * LW;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, le_ab, le_ba, oe_ab, oe_ba, bypass, odd_sel;
   logic [LANES-1:0] cen_ab, cen_ba, err_a_n, err_b_n;
   logic [W-1:0] a_in, b_in, a_out, b_out;
   logic a_oe, b_oe;

   int n_chk = 0;
   int n_bad = 0;
   logic [W-1:0] m_ab = '0;
   logic [W-1:0] m_ba = '0;

   parity_xcvr uut (
      .clk_ab(clk), .clk_ba(clk), .rst_n(rst_n),
      .le_ab(le_ab), .le_ba(le_ba), .cen_ab(cen_ab), .cen_ba(cen_ba),
      .oe_ab(oe_ab), .oe_ba(oe_ba), .bypass(bypass), .odd_sel(odd_sel),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
      .err_a_n(err_a_n), .err_b_n(err_b_n)
   );

   function automatic logic [W-1:0] f_out(logic [W-1:0] s, logic byp, logic odd);
      logic [W-1:0] r = s;
      if (!byp)
         for (int i = 0; i < LANES; i++)
            r[i*LW + 8] = (^s[i*LW +: 8]) ^ odd;
      return r;
   endfunction

   function automatic logic [LANES-1:0] f_err(logic [W-1:0] s, logic byp, logic odd);
      logic [LANES-1:0] r = '1;
      if (!byp)
         for (int i = 0; i < LANES; i++)
            r[i] = ((^s[i*LW +: LW]) == odd);
      return r;
   endfunction

   task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // compare every output with the model, shortly after inputs settle
   task automatic observe(string tag);
      logic [W-1:0] e_ab, e_ba;
      #1;
      e_ab = le_ab ? a_in : m_ab;
      e_ba = le_ba ? b_in : m_ba;
      chk({tag, " b_out"}, b_out, f_out(e_ab, bypass, odd_sel));
      chk({tag, " err_a_n"}, W'(err_a_n), W'(f_err(e_ab, bypass, odd_sel)));
      chk({tag, " a_out"}, a_out, f_out(e_ba, bypass, odd_sel));
      chk({tag, " err_b_n"}, W'(err_b_n), W'(f_err(e_ba, bypass, odd_sel)));
      chk({tag, " R9 oe"}, W'({a_oe, b_oe}), W'({oe_ba, oe_ab}));
   endtask

   task automatic tick();
      @(posedge clk);
      if (!rst_n) begin
         m_ab = '0;
         m_ba = '0;
      end else begin
         for (int i = 0; i < LANES; i++) begin
            if (le_ab || cen_ab[i]) m_ab[i*LW +: LW] = a_in[i*LW +: LW];
            if (le_ba || cen_ba[i]) m_ba[i*LW +: LW] = b_in[i*LW +: LW];
         end
      end
      @(negedge clk);
   endtask

   initial begin
      #(8 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4051));
      rst_n = 0; le_ab = 0; le_ba = 0; oe_ab = 0; oe_ba = 0;
      bypass = 1; odd_sel = 0; cen_ab = '0; cen_ba = '0;
      a_in = '0; b_in = '0;
      tick(); tick();
      observe("R1 reset bypass");
      chk("R1 zero", b_out, '0);
      rst_n = 1;
      bypass = 0; odd_sel = 1;
      #1;
      chk("R1 odd regen", b_out, 18'h20100);
      chk("R7 reset flags", W'({err_a_n, err_b_n}), W'(4'b0000));

      // R2 transparent, even parity, plus error injection per lane
      le_ab = 1; odd_sel = 0; oe_ab = 1;
      a_in = 18'h00701;
      #1;
      chk("R2 transparent", b_out, 18'h00701);
      chk("R7 clean", W'(err_a_n), W'(2'b11));
      a_in = 18'h00701 ^ 18'h20000;
      #1;
      chk("R5 parity regen lane1", b_out, 18'h00701);
      chk("R7 lane1 error", W'(err_a_n), W'(2'b01));
      a_in = 18'h00701 ^ 18'h00001;
      #1;
      chk("R5 lane0 data", b_out, 18'h00600);
      chk("R7 lane0 error", W'(err_a_n), W'(2'b10));
      observe("R2 model");
      odd_sel = 1;
      observe("R6 odd");

      // R3/R4 register mode, per lane
      a_in = '0; tick();
      le_ab = 0; bypass = 1; cen_ab = 2'b01; a_in = 18'h3FFFF;
      tick();
      chk("R3 lane0 load", b_out, 18'h001FF);
      cen_ab = 2'b10; a_in = '0;
      tick();
      chk("R4 lane0 hold", b_out, 18'h001FF);
      cen_ab = 2'b00; a_in = 18'h2AAAA;
      tick();
      chk("R4 both hold", b_out, 18'h001FF);
      observe("R4 model");

      // R10 B-to-A independent of A-to-B controls
      le_ba = 0; cen_ba = 2'b10; b_in = 18'h15555; oe_ba = 1;
      tick();
      chk("R10 lane1 load", a_out, 18'h15400);
      chk("R10 ab unaffected", b_out, 18'h001FF);
      le_ab = 1;
      #1;
      chk("R10 ba unaffected", a_out, 18'h15400);
      observe("R10 model");

      // R8 bypass with parity errors present
      bypass = 1; a_in = 18'h00001; le_ab = 1;
      #1;
      chk("R8 raw pass", b_out, 18'h00001);
      chk("R8 flags high", W'(err_a_n), W'(2'b11));

      // random mix
      for (int k = 0; k < 2000; k++) begin
         le_ab   = ($urandom % 4) == 0;
         le_ba   = ($urandom % 4) == 0;
         cen_ab  = LANES'($urandom);
         cen_ba  = LANES'($urandom);
         bypass  = ($urandom % 4) == 0;
         odd_sel = 1'($urandom);
         oe_ab   = 1'($urandom);
         oe_ba   = 1'($urandom);
         a_in    = W'($urandom);
         b_in    = W'($urandom);
         observe("R3 R4 R5 R7 random");
         tick();
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule